// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block derives the clock driven to an SD or MMC card from a fixed host reference clock (nominally 24 MHz). A 16-bit control word, written through a simple register port, holds a power-of-two divide code, a clock enable and a bypass request. A separate clock-mode input selects between divided operation and a full-rate pass-through of the host clock. With the default settings the card clock ranges from 46875 Hz (divide by 512) up to the full 24 MHz.

The control word is written in one cycle and can be read back at any time. The card clock output is glitch-free. A divided clock only stops, starts or changes ratio at the end of a low phase, so a high pulse that has begun always runs to its full width. The bypass gate opens and closes only while the host clock is low.

There is no data stream here. Every pin is a plain level-sensitive control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `sd_card_clk_ctl`

## Requirements
- R1: After reset the control word reads 0x0000 and card_clk is held low.
- R2: A write stores all 16 bits of wr_data. From the cycle after the write, rd_data returns that exact value until the next write.
- R3: While bit 8 (enable) of the control word is 0, card_clk stays low. Writing 0x0000 stops a running clock.
- R4: A divide code of 0x00 in bits [7:0], with enable set and not in bypass, gives divide by 2: one host cycle high, then one host cycle low.
- R5: A code with only bit p set (p = 0..7) gives divide by 2^(p+2), at 50 % duty. For example, 0x01 gives divide by 4 and 0x80 gives divide by 512.
- R6: A code with several bits set behaves as if only its highest set bit were set.
- R7: With bits 15 and 8 set and mode_div = 0, card_clk follows the host clock: high while clk is high and low while clk is low.
- R8: mode_div only matters when bit 15 is set. With bit 15 set and mode_div = 1, the clock is divided by the code. With bit 15 clear, the clock is divided whatever mode_div is.
- R9: Bits 14 to 9 are stored and read back but have no effect on card_clk.
- R10: A high pulse that is under way when the enable is cleared or the code changes keeps its full old width. The following low phase also keeps the old width, and the new setting applies from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to store |
| mode_div | input | 1 | Clock mode: 1 = divided, 0 = allow bypass when bit 15 is set |
| rd_data | output | 16 | Current control word |
| card_clk | output | 1 | Gated clock to the card pin |

## Verification
A write is captured on the host clock edge where wr_en is high, and rd_data shows the new value at the very next sample point. A divided setting takes effect at the end of the current low phase, which can be up to 256 host cycles later. The scoreboard monitor therefore discards one full pulse after each new expectation and then measures the high and low run lengths of the next pulse by sampling at falling host edges. The bypass gate changes on a falling edge, so bypass output is checked a quarter period into each phase after a few cycles of settling. The mid-pulse tests write on a counted sample inside a known high phase and then count that pulse and its low phase to completion.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // width of the divide code field at the bottom of the control word
  localparam int CODE_W  = 8;
  // shift amount covers 0 (code zero) up to CODE_W (top bit set)
  localparam int SHIFT_W = $clog2(CODE_W + 2);

  typedef struct packed {
    logic               run;    // divided clock enabled
    logic               byp;    // full-rate pass-through requested
    logic [SHIFT_W-1:0] shift;  // half period = 2**shift host cycles
  } clk_cfg_t;
endpackage

// File: rtl/sdclk_ctl_reg.sv
module sdclk_ctl_reg
  import sdclk_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int EN_BIT  = 8,
  parameter int BYP_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mode_div,
  output logic [REG_W-1:0] rd_data,
  output clk_cfg_t         cfg
);
  logic [REG_W-1:0]  ctl_q;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data;
  end

  assign rd_data = ctl_q;
  assign code    = ctl_q[CODE_W-1:0];

  // priority decode: the highest set code bit picks the ratio
  always_comb begin
    cfg.shift = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (code[i]) cfg.shift = SHIFT_W'(i + 1);
    end
    cfg.byp = ctl_q[EN_BIT] & ctl_q[BYP_BIT] & ~mode_div;
    cfg.run = ctl_q[EN_BIT] & ~cfg.byp;
  end
endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
  import sdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_cfg_t cfg_in,
  output logic     div_clk,
  output logic     byp_act
);
  localparam int CNT_W = CODE_W;

  clk_cfg_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             div_q;
  logic [CNT_W:0]   half_full;
  logic [CNT_W-1:0] half_m1;

  assign half_full = (CNT_W + 1)'(1) << act_q.shift;
  assign half_m1   = CNT_W'(half_full - 1'b1);

  // the active setting is only replaced while idle or at the end of a low phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!act_q.run) begin
      act_q <= cfg_in;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      if (div_q) begin
        div_q <= 1'b0;
      end else begin
        act_q <= cfg_in;
        div_q <= cfg_in.run;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_clk = div_q;
  assign byp_act = act_q.byp;
endmodule

// File: rtl/sdclk_out_gate.sv
module sdclk_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_req,
  input  logic div_clk,
  output logic card_clk
);
  logic gate_q;

  // gate flips on the falling edge so the pass-through never cuts a high phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= byp_req;
  end

  assign card_clk = div_clk | (clk & gate_q);
endmodule

// File: rtl/sd_card_clk_ctl.sv
module sd_card_clk_ctl
  import sdclk_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int EN_BIT  = 8,
  parameter int BYP_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mode_div,
  output logic [REG_W-1:0] rd_data,
  output logic             card_clk
);
  clk_cfg_t cfg;
  logic     div_clk;
  logic     byp_act;

  sdclk_ctl_reg #(.REG_W(REG_W), .EN_BIT(EN_BIT), .BYP_BIT(BYP_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_div(mode_div), .rd_data(rd_data), .cfg(cfg)
  );

  sdclk_div_core u_div (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg),
    .div_clk(div_clk), .byp_act(byp_act)
  );

  sdclk_out_gate u_gate (
    .clk(clk), .rst_n(rst_n), .byp_req(byp_act),
    .div_clk(div_clk), .card_clk(card_clk)
  );
endmodule

// File: rtl/sdclk_checker.sv
module sdclk_checker #(
  parameter int REG_W   = 16,
  parameter int EN_BIT  = 8,
  parameter int BYP_BIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             mode_div,
  input logic [REG_W-1:0] rd_data,
  input logic             div_clk,
  input logic             byp_act
);
  // R2: a write is visible on the next cycle
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R2: without a write the word holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R3: a disabled clock that is low stays low
  assert_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[EN_BIT] && !div_clk) |=> !div_clk);

  // R7: pass-through only when requested with the mode bit cleared
  assert_bypass_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byp_act |-> $past(rd_data[BYP_BIT] && rd_data[EN_BIT] && !mode_div));

  // R10: divided and pass-through paths never drive together
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_clk && byp_act));
endmodule

bind sd_card_clk_ctl sdclk_checker #(.REG_W(REG_W), .EN_BIT(EN_BIT), .BYP_BIT(BYP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .mode_div(mode_div), .rd_data(rd_data), .div_clk(div_clk), .byp_act(byp_act)
);

// File: tb/tb_sd_card_clk_ctl.sv
`timescale 1ns/1ps
module tb_sd_card_clk_ctl;
  localparam int LIM = 1300;

  typedef struct { int half; string rq; } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        mode_div = 1'b1;
  logic [15:0] rd_data;
  logic        card_clk;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  sd_card_clk_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_div(mode_div), .rd_data(rd_data), .card_clk(card_clk)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_check(input logic [15:0] v);
    write_reg(v);
    chk(rd_data == v, "R2", "readback", int'(rd_data), int'(v));
  endtask

  // driver: push expected half period, wait for the monitor to consume it
  task automatic expect_half(input int half, input string rq);
    exp_t e;
    e.half = half; e.rq = rq;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic measure(output int hi, output int lo);
    int g;
    hi = -1; lo = -1; g = 0;
    @(negedge clk);
    while (card_clk && g < LIM) begin @(negedge clk); g++; end
    while (!card_clk && g < LIM) begin @(negedge clk); g++; end
    if (g >= LIM) return;
    hi = 0;
    while (card_clk && g < LIM) begin hi++; @(negedge clk); g++; end
    lo = 0;
    while (!card_clk && g < LIM) begin lo++; @(negedge clk); g++; end
    if (g >= LIM) lo = -1;
  endtask

  // monitor: one pulse is skipped, the next is compared
  initial begin
    forever begin
      int hi, lo;
      wait (exp_q.size() > 0);
      measure(hi, lo);
      measure(hi, lo);
      chk(hi == exp_q[0].half, exp_q[0].rq, "high run", hi, exp_q[0].half);
      chk(lo == exp_q[0].half, exp_q[0].rq, "low run", lo, exp_q[0].half);
      void'(exp_q.pop_front());
    end
  end

  task automatic check_stopped(input int n, input string rq);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1.25; if (card_clk) bad++;
      @(negedge clk); #1.25; if (card_clk) bad++;
    end
    chk(bad == 0, rq, "high samples while stopped", bad, 0);
  endtask

  task automatic check_bypass(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1.25; if (!card_clk) bad++;
      @(negedge clk); #1.25; if (card_clk) bad++;
    end
    chk(bad == 0, "R7", "bypass phase errors", bad, 0);
  endtask

  // R10: write v on the third high sample of a pulse, count the pulse and its low phase
  task automatic mid_pulse(input logic [15:0] v, output int hi, output int lo);
    int g = 0;
    @(negedge clk);
    while (card_clk && g < LIM) begin @(negedge clk); g++; end
    while (!card_clk && g < LIM) begin @(negedge clk); g++; end
    hi = 1;
    forever begin
      if (hi == 3) begin wr_en = 1'b1; wr_data = v; end
      @(negedge clk);
      wr_en = 1'b0;
      if (card_clk && hi < LIM) hi++;
      else break;
    end
    lo = 1;
    while (lo < 40) begin
      @(negedge clk);
      if (card_clk) break;
      lo++;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h0000, "R1", "reset word", int'(rd_data), 0);
    check_stopped(20, "R1");

    // R9, R3: high bits stored but enable clear keeps the clock stopped
    write_check(16'h7E5A);
    check_stopped(40, "R3");

    mode_div = 1'b1;
    write_check(16'h0100);
    expect_half(1, "R4");

    for (int p = 0; p < 8; p++) begin
      write_check(16'h0100 | (16'h1 << p));
      expect_half(1 << (p + 1), "R5");
    end

    write_check(16'h0106);
    expect_half(8, "R6");
    write_check(16'h01FF);
    expect_half(256, "R6");

    // R9 and R8: bits 14..9 ignored, bit 15 clear divides even with mode cleared
    mode_div = 1'b0;
    write_check(16'h7F04);
    expect_half(8, "R9");

    mode_div = 1'b1;
    write_check(16'h8101);
    expect_half(2, "R8");

    mode_div = 1'b0;
    repeat (6) @(negedge clk);
    check_bypass(20);

    mode_div = 1'b1;
    expect_half(2, "R8");

    // R10: ratio change mid-pulse
    write_check(16'h0104);
    expect_half(8, "R5");
    mid_pulse(16'h0101, hi, lo);
    chk(hi == 8, "R10", "pulse width at ratio change", hi, 8);
    chk(lo == 8, "R10", "low width at ratio change", lo, 8);
    expect_half(2, "R10");

    // R10, R3: disable mid-pulse
    write_check(16'h0104);
    expect_half(8, "R5");
    mid_pulse(16'h0000, hi, lo);
    chk(hi == 8, "R10", "pulse width at disable", hi, 8);
    chk(lo == 40, "R3", "low samples after disable", lo, 40);
    chk(rd_data == 16'h0000, "R2", "readback after disable", int'(rd_data), 0);
    check_stopped(300, "R3");

    finish_run();
  end
endmodule